// File: doc/BRIEF.md
# Three-Wire Serial Memory Slave

This block is the slave side of a three-wire serial link (chip select, serial clock, data in, plus a data-out line with its own output enable) sitting in front of a small register-file memory. The block runs on the system clock. It samples the serial pins as ordinary synchronous inputs and acts on each rising edge of the serial clock while chip select is high. The host sends a start bit, a two-bit opcode and an address. For write-type commands a data word follows. Reads stream words back without further commands. Writes, erases and the two whole-array commands are armed during the transfer and launched when chip select falls.

Each launched cycle goes to an external timing sequencer over a start/busy handshake. The array is updated when the sequencer drops busy. Until then, raising chip select puts the live ready/busy state on the data-out line. An organization input selects 16-bit words or 8-bit bytes over the same storage. Word `a` in 16-bit mode is byte `2a+1` (high half) joined to byte `2a` (low half).

Top module: `mw_mem_slave`

## Requirements
- R1: After reset the data-out enable is low, `seq_start` is low, writes are disabled and every storage byte reads as 8'hFF.
- R2: Zeros clocked in before the first 1 are ignored. A command is a 1 start bit, then a 2-bit opcode, then the address MSB first. The address is AW bits with `org16`=1 and AW+1 bits with `org16`=0.
- R3: Opcode 2'b10 reads. The rising clock edge that takes the last address bit enables data out and drives a 0. Each following edge presents the next data bit, MSB first: 16 bits with `org16`=1, 8 bits otherwise.
- R4: While chip select stays high, the next word follows directly with no dummy bit, at the address plus one. The address wraps to 0 after the top of the address space (2^AW words or 2^(AW+1) bytes).
- R5: With opcode 2'b00, the two most significant address bits select a special command. 2'b11 sets the write-enable latch, 2'b00 clears it, 2'b10 is clear-all and 2'b01 is write-all. While the latch is clear, write, erase, clear-all and write-all launch nothing and change nothing.
- R6: Opcode 2'b01 writes one location with a data field that follows the address (16 bits in word mode, 8 bits in byte mode), using the byte mapping given above.
- R7: Opcode 2'b11 sets one location to all ones. Clear-all sets every byte to 8'hFF. Write-all stores its data in every location.
- R8: An armed command is launched on the falling edge of chip select. `seq_start` goes high on the next clock and stays high until `seq_busy` is seen high. The array changes when `seq_busy` then falls.
- R9: After a launch, the next rise of chip select enables data out, which shows 0 while the cycle runs and 1 once it is done. A 1 clocked in on data in returns data out to high impedance.
- R10: Chip select falling before a command is complete discards it, with no launch and no change.
- R11: While a cycle is running, new commands are ignored and data out stays disabled.
- R12: The data-out enable is low whenever chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, acts as power-up |
| org16 | input | 1 | 1 selects 16-bit words, 0 selects 8-bit bytes |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock, sampled on clk |
| di | input | 1 | Serial data in |
| do_o | output | 1 | Serial data out value |
| do_oe | output | 1 | Serial data out enable |
| seq_start | output | 1 | Request to the write-cycle sequencer |
| seq_busy | input | 1 | Sequencer is running a cycle |

## Verification
The hardest state to reach is a running write cycle with chip select high and serial traffic arriving. The bench plays the sequencer itself and holds `seq_busy` high after acknowledging `seq_start`. It then raises chip select to see the busy status, clocks a 1 to release the line, and pushes a complete read command that must produce nothing. The reference model tracks the expected array byte by byte. It also compares the enable and the data value on every clock.

// File: rtl/mw_mem_slave.sv
module mw_mem_slave #(
  parameter int AW = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic org16,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic do_o,
  output logic do_oe,
  output logic seq_start,
  input  logic seq_busy
);
  localparam int NB = 2 ** (AW + 1);
  localparam int CW = $clog2(AW + 20);

  typedef enum logic [1:0] {P_IDLE, P_SHIFT, P_DONE, P_READ} ph_t;
  typedef enum logic [1:0] {S_IDLE, S_REQ, S_RUN} sq_t;

  logic [7:0] mem [NB];
  ph_t ph;
  sq_t sq;
  logic sk_q, cs_q, wen_q, armed, is_erase, is_all, status_q, poll_q, do_r;
  logic [CW-1:0] bcnt;
  logic [1:0] op;
  logic [AW:0] addr, rd_addr, l_addr;
  logic [15:0] dat, rd_sh, l_dat;
  logic [4:0] rd_cnt;
  logic l_all, l_org;

  wire sk_rise = cs & sk & ~sk_q;
  wire cs_fall = cs_q & ~cs;
  wire cs_rise = cs & ~cs_q;
  wire busy = sq != S_IDLE;
  wire [CW-1:0] a_end = CW'(org16 ? AW + 1 : AW + 2);
  wire [CW-1:0] d_end = a_end + CW'(org16 ? 16 : 8);
  wire [AW:0] new_addr = {addr[AW-1:0], di};
  wire [1:0] top2 = org16 ? new_addr[AW-1:AW-2] : new_addr[AW:AW-1];
  wire [15:0] new_dat = {dat[14:0], di};
  wire [AW:0] amask = org16 ? {1'b0, {AW{1'b1}}} : {(AW+1){1'b1}};
  wire [15:0] rd_word = org16 ? {mem[{rd_addr[AW-1:0], 1'b1}], mem[{rd_addr[AW-1:0], 1'b0}]}
                              : {mem[rd_addr], 8'h00};
  wire launch = cs_fall && ph == P_DONE && armed && wen_q && !busy;

  assign do_o = status_q ? ~busy : do_r;
  assign do_oe = cs & (status_q | ph == P_READ);
  assign seq_start = sq == S_REQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sk_q <= 1'b0; cs_q <= 1'b0;
    end else begin
      sk_q <= sk; cs_q <= cs;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= P_IDLE; bcnt <= '0; op <= '0; addr <= '0; dat <= '0;
      wen_q <= 1'b0; armed <= 1'b0; is_erase <= 1'b0; is_all <= 1'b0;
      status_q <= 1'b0; do_r <= 1'b0; rd_addr <= '0; rd_sh <= '0; rd_cnt <= '0;
    end else if (!cs) begin
      ph <= P_IDLE; armed <= 1'b0; status_q <= 1'b0;
    end else begin
      if (cs_rise && poll_q) status_q <= 1'b1;
      if (sk_rise) begin
        if (status_q) begin
          if (di) status_q <= 1'b0;
        end else begin
          case (ph)
            P_IDLE: if (di && !busy) begin ph <= P_SHIFT; bcnt <= '0; end
            P_SHIFT: begin
              bcnt <= bcnt + 1'b1;
              if (bcnt < 2) op <= {op[0], di};
              else if (bcnt <= a_end) addr <= new_addr;
              else dat <= new_dat;
              if (bcnt == a_end) begin
                is_all <= 1'b0; is_erase <= 1'b0;
                case (op)
                  2'b10: begin ph <= P_READ; do_r <= 1'b0; rd_cnt <= '0; rd_addr <= new_addr & amask; end
                  2'b11: begin ph <= P_DONE; armed <= 1'b1; is_erase <= 1'b1; end
                  2'b01: ;
                  default: case (top2)
                    2'b11: begin wen_q <= 1'b1; ph <= P_DONE; end
                    2'b00: begin wen_q <= 1'b0; ph <= P_DONE; end
                    2'b10: begin ph <= P_DONE; armed <= 1'b1; is_erase <= 1'b1; is_all <= 1'b1; end
                    default: is_all <= 1'b1;
                  endcase
                endcase
              end else if (bcnt == d_end) begin
                ph <= P_DONE; armed <= 1'b1;
              end
            end
            P_READ: begin
              if (rd_cnt == 0) begin
                do_r <= rd_word[15];
                rd_sh <= {rd_word[14:0], 1'b0};
                rd_cnt <= org16 ? 5'd15 : 5'd7;
                rd_addr <= (rd_addr + 1'b1) & amask;
              end else begin
                do_r <= rd_sh[15];
                rd_sh <= {rd_sh[14:0], 1'b0};
                rd_cnt <= rd_cnt - 1'b1;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq <= S_IDLE; poll_q <= 1'b0; l_all <= 1'b0; l_org <= 1'b0; l_addr <= '0; l_dat <= '0;
      for (int i = 0; i < NB; i++) mem[i] <= 8'hFF;
    end else begin
      if (launch) begin
        sq <= S_REQ; poll_q <= 1'b1;
        l_all <= is_all; l_org <= org16; l_addr <= addr & amask;
        l_dat <= is_erase ? 16'hFFFF : dat;
      end else if (cs_rise) begin
        poll_q <= 1'b0;
      end
      if (sq == S_REQ && seq_busy) sq <= S_RUN;
      if (sq == S_RUN && !seq_busy) begin
        sq <= S_IDLE;
        if (l_all) begin
          for (int i = 0; i < NB; i++) mem[i] <= (l_org && (i % 2 == 1)) ? l_dat[15:8] : l_dat[7:0];
        end else if (l_org) begin
          mem[{l_addr[AW-1:0], 1'b1}] <= l_dat[15:8];
          mem[{l_addr[AW-1:0], 1'b0}] <= l_dat[7:0];
        end else begin
          mem[l_addr] <= l_dat[7:0];
        end
      end
    end
  end
endmodule

// File: rtl/mw_mem_slave_chk.sv
module mw_mem_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic cs,
  input logic do_oe,
  input logic seq_start,
  input logic seq_busy,
  input logic wen
);
  p_oe_needs_cs_r12: assert property (@(posedge clk) disable iff (!rst_n) !cs |-> !do_oe);
  p_start_holds_r8: assert property (@(posedge clk) disable iff (!rst_n) seq_start && !seq_busy |=> seq_start);
  p_start_drops_r8: assert property (@(posedge clk) disable iff (!rst_n) seq_start && seq_busy |=> !seq_start);
  p_launch_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n) $rose(seq_start) |-> !$past(cs));
  p_launch_needs_wen_r5: assert property (@(posedge clk) disable iff (!rst_n) $rose(seq_start) |-> $past(wen));
endmodule

bind mw_mem_slave mw_mem_slave_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cs(cs), .do_oe(do_oe),
  .seq_start(seq_start), .seq_busy(seq_busy), .wen(wen_q)
);

// File: tb/mw_mem_slave_tb_top.sv
`timescale 1ns/1ps
module mw_mem_slave_tb_top;
  localparam int AW = 6;
  logic clk = 0, rst_n = 0, org16 = 1, cs = 0, sk = 0, di = 0, seq_busy = 0;
  logic do_o, do_oe, seq_start;
  int checks = 0, errors = 0;
  bit exp_oe = 0, exp_do = 0, cmp_on = 0;
  string cur = "R1";
  logic [7:0] m [2**(AW+1)];

  always #2 clk = ~clk;

  mw_mem_slave #(.AW(AW)) dut_i (.clk(clk), .rst_n(rst_n), .org16(org16), .cs(cs), .sk(sk),
    .di(di), .do_o(do_o), .do_oe(do_oe), .seq_start(seq_start), .seq_busy(seq_busy));

  initial forever begin
    @(posedge clk); #1;
    if (cmp_on) begin
      checks++;
      if (do_oe !== exp_oe || (exp_oe && do_o !== exp_do)) begin
        errors++;
        $display("FAIL %s: oe=%b do=%b expected oe=%b do=%b", cur, do_oe, do_o, exp_oe, exp_do);
      end
    end
  end

  task automatic chk(string r, logic act, logic exp);
    checks++;
    if (act !== exp) begin errors++; $display("FAIL %s: got %b expected %b", r, act, exp); end
  endtask

  function automatic logic [15:0] mword(int a, bit o16);
    return o16 ? {m[2*a+1], m[2*a]} : {8'h00, m[a]};
  endfunction

  task automatic bit_io(bit b, bit eoe, bit edo);
    @(negedge clk); di = b; sk = 1; exp_oe = eoe; exp_do = edo;
    @(negedge clk); sk = 0;
    @(negedge clk);
  endtask

  task automatic cs_up(bit eoe, bit edo);
    @(negedge clk); cs = 1; exp_oe = eoe; exp_do = edo;
  endtask

  task automatic cs_down();
    @(negedge clk); cs = 0; sk = 0; exp_oe = 0;
  endtask

  task automatic cmd(logic [1:0] op, int a, logic [15:0] d, bit ign);
    int al = org16 ? AW : AW + 1;
    int dl = org16 ? 16 : 8;
    bit_io(1, 0, 0);
    bit_io(op[1], 0, 0); bit_io(op[0], 0, 0);
    for (int i = al - 1; i >= 0; i--) bit_io(a[i], (op == 2'b10 && i == 0 && !ign), 0);
    if (op == 2'b01 || (op == 2'b00 && a[al-1 -: 2] == 2'b01))
      for (int i = dl - 1; i >= 0; i--) bit_io(d[i], 0, 0);
  endtask

  task automatic read_seq(int a, int n);
    int dl = org16 ? 16 : 8;
    int top = org16 ? 2**AW : 2**(AW+1);
    for (int w = 0; w < n; w++) begin
      logic [15:0] v = mword(a, org16);
      for (int i = dl - 1; i >= 0; i--) bit_io(0, 1, v[i]);
      a = (a + 1) % top;
    end
  endtask

  task automatic do_read(int a, int n);
    cs_up(0, 0); cmd(2'b10, a, 0, 0); read_seq(a, n); cs_down();
  endtask

  task automatic spec(logic [1:0] t, logic [15:0] d);
    int al = org16 ? AW : AW + 1;
    cmd(2'b00, int'(t) << (al - 2), d, 0);
  endtask

  task automatic launch_run();
    @(negedge clk); chk("R8 start after fall", seq_start, 1);
    seq_busy = 1;
    repeat (3) @(negedge clk);
    chk("R8 start released", seq_start, 0);
    cs_up(1, 0);
    repeat (4) @(negedge clk);
    seq_busy = 0; exp_do = 1;
    repeat (3) @(negedge clk);
    bit_io(1, 0, 0);
    cs_down();
  endtask

  task automatic no_launch(string r);
    repeat (4) begin @(negedge clk); chk(r, seq_start, 0); end
  endtask

  initial begin
    for (int i = 0; i < 2**(AW+1); i++) m[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 oe", do_oe, 0); chk("R1 start", seq_start, 0);
    cmp_on = 1;

    cur = "R5"; cs_up(0, 0); cmd(2'b01, 5, 16'h1111, 0); cs_down(); no_launch("R5 write disabled");
    cur = "R1"; do_read(5, 1);

    cur = "R5"; cs_up(0, 0); spec(2'b11, 0); cs_down();
    cur = "R6"; cs_up(0, 0); cmd(2'b01, 5, 16'hA5C3, 0); cs_down();
    cur = "R9"; launch_run(); m[11] = 8'hA5; m[10] = 8'hC3;
    cur = "R3"; do_read(5, 2);
    cur = "R2"; cs_up(0, 0); bit_io(0, 0, 0); bit_io(0, 0, 0); cmd(2'b10, 5, 0, 0); read_seq(5, 1); cs_down();

    cur = "R6"; cs_up(0, 0); cmd(2'b01, 63, 16'h0F0F, 0); cs_down();
    cur = "R8"; launch_run(); m[127] = 8'h0F; m[126] = 8'h0F;
    cur = "R4"; do_read(63, 2);

    org16 = 0;
    cur = "R6"; cs_up(0, 0); cmd(2'b01, 10, 16'h005A, 0); cs_down();
    cur = "R8"; launch_run(); m[10] = 8'h5A;
    cur = "R3"; do_read(10, 2);
    cur = "R4"; do_read(127, 2);
    org16 = 1;
    cur = "R6"; do_read(5, 1);

    cur = "R7"; cs_up(0, 0); cmd(2'b11, 5, 0, 0); cs_down();
    launch_run(); m[10] = 8'hFF; m[11] = 8'hFF;
    do_read(5, 1);
    cs_up(0, 0); spec(2'b01, 16'h1234); cs_down();
    launch_run();
    for (int i = 0; i < 2**(AW+1); i++) m[i] = (i % 2) ? 8'h12 : 8'h34;
    do_read(62, 3);
    cs_up(0, 0); spec(2'b10, 0); cs_down();
    launch_run();
    for (int i = 0; i < 2**(AW+1); i++) m[i] = 8'hFF;
    do_read(7, 1);

    cur = "R10"; cs_up(0, 0); bit_io(1, 0, 0); bit_io(0, 0, 0); bit_io(1, 0, 0); bit_io(0, 0, 0);
    cs_down(); no_launch("R10 abort");
    do_read(2, 1);

    cur = "R11"; cs_up(0, 0); cmd(2'b01, 9, 16'h0001, 0); cs_down();
    @(negedge clk); chk("R11 start", seq_start, 1); seq_busy = 1;
    repeat (2) @(negedge clk);
    cs_up(1, 0); bit_io(1, 0, 0); cmd(2'b10, 9, 0, 1);
    chk("R11 oe while busy", do_oe, 0);
    cs_down();
    cur = "R12"; @(negedge clk); chk("R12 oe with cs low", do_oe, 0);
    seq_busy = 0; m[19] = 8'h00; m[18] = 8'h01;
    repeat (3) @(negedge clk);
    cur = "R11"; do_read(9, 1);

    cur = "R5"; cs_up(0, 0); spec(2'b00, 0); cs_down();
    cs_up(0, 0); cmd(2'b11, 9, 0, 0); cs_down(); no_launch("R5 erase disabled");
    do_read(9, 1);

    cmp_on = 0;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule